// File: doc/BRIEF.md
# Majority-Vote Serial Receiver

This block receives asynchronous serial frames on a single line. A tick input marks sixteenth-of-a-bit intervals. Each bit is sampled three times around its centre and settled by a two-out-of-three vote. Where the three samples disagree, a noise flag is set and the frame is still accepted. The frame shape is chosen by configuration inputs: eight or nine data bits, an optional parity bit with even or odd sense, and one or two stop bits.

Completed words move into a holding stage that is clocked on the falling clock edge. That stage keeps the word together with its noise and frame-error flags, and it raises a full flag until a read strobe empties it. If a frame arrives while the stage is still full, the overrun flag is set. A run of ten zero bits is reported as a break. Separate enable inputs gate the interrupt requests for full, overrun and break.

Top module: `uart_rx_majority`

## Requirements
- R1: Each bit is sampled at ticks 7, 8 and 9 of its 16-tick period, counted from the start-bit edge. The bit value is the level shown by at least two of the three samples.
- R2: If the three samples of any bit disagree, from the start bit to the last stop bit, the frame is still received and `rxNoise` is 1 for that word.
- R3: A frame is a start bit, then 8 data bits (9 when `cfgNineBit`=1) sent LSB first, then a parity bit when `cfgParityEn`=1, then one stop bit (two when `cfgTwoStop`=1). In 8-bit mode, `rxWord[8]` is 0.
- R4: `rxFrameErr` is 1 for a word if any stop bit resolves to 0. It is also 1 if parity is enabled and the data bits plus the parity bit hold an odd count of ones (`cfgParityOdd`=0) or an even count of ones (`cfgParityOdd`=1).
- R5: Ten consecutive resolved 0 bits within a frame set `rxBreak`. The flag stays set until a read strobe.
- R6: A completed frame that finds the holding stage empty loads `rxWord`, `rxNoise` and `rxFrameErr`, and sets `rxFull`.
- R7: `rdStrobe` clears `rxFull`, `rxOverrun` and `rxBreak`.
- R8: A frame that completes while `rxFull`=1 sets `rxOverrun`. The older word and its flags stay unchanged.
- R9: `irqFull`, `irqOverrun` and `irqBreak` each equal their status flag ANDed with the matching enable input. A disabled source still sets its flag.
- R10: A falling edge on the idle line starts a frame only if the vote at the start bit's mid-point gives 0. Otherwise the receiver returns to idle and no word is produced.
- R11: After reset, `rxFull`, all status flags and all interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; the holding stage uses its falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| cfgNineBit | input | 1 | 1 = nine data bits |
| cfgParityEn | input | 1 | 1 = parity bit present and checked |
| cfgParityOdd | input | 1 | 1 = odd parity, 0 = even |
| cfgTwoStop | input | 1 | 1 = two stop bits |
| enFullIrq | input | 1 | Enable for the full interrupt |
| enOverrunIrq | input | 1 | Enable for the overrun interrupt |
| enBreakIrq | input | 1 | Enable for the break interrupt |
| rdStrobe | input | 1 | Empties the holding stage and clears flags |
| rxWord | output | 9 | Held received word |
| rxFull | output | 1 | Holding stage holds an unread word |
| rxNoise | output | 1 | Sample disagreement in the held word |
| rxFrameErr | output | 1 | Parity or stop failure in the held word |
| rxOverrun | output | 1 | A word was lost while full |
| rxBreak | output | 1 | Ten-zero run seen |
| irqFull | output | 1 | Gated full request |
| irqOverrun | output | 1 | Gated overrun request |
| irqBreak | output | 1 | Gated break request |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit, an 8-bit base word and a break length of 10. With these values a plain 8-bit frame held low from start to stop is exactly a break, so the break and frame-error paths can be reached in one frame. The bench drives a tick every fourth clock, which keeps frames short enough for many random configurations. It aligns its line changes to tick edges so that a one-tick glitch lands on exactly one of the three vote samples, for any chosen bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    KIND_START  = 2'd0,
    KIND_DATA   = 2'd1,
    KIND_PARITY = 2'd2,
    KIND_STOP   = 2'd3
  } bitKind_t;

  typedef struct packed {
    logic     frameStart;
    logic     sampleA;
    logic     sampleB;
    logic     resolve;
    logic     lastBit;
    bitKind_t kind;
  } rxStrobe_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      lineFall,
  input  logic      vote,
  input  logic      cfgNineBit,
  input  logic      cfgParityEn,
  input  logic      cfgTwoStop,
  output rxStrobe_t strobe
);

  localparam int TW     = $clog2(OVS);
  localparam int MID    = OVS / 2;
  localparam int IDX_W  = $clog2(DATA_W + 5);
  localparam logic [TW-1:0] SAMP_A = TW'(MID - 1);
  localparam logic [TW-1:0] SAMP_B = TW'(MID);
  localparam logic [TW-1:0] SAMP_C = TW'(MID + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(OVS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BITS} ctrlState_t;

  ctrlState_t       state;
  logic [TW-1:0]    tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] dataBits;
  logic [IDX_W-1:0] totalBits;

  assign dataBits  = IDX_W'(DATA_W) + IDX_W'(cfgNineBit);
  assign totalBits = dataBits + IDX_W'(cfgParityEn) + IDX_W'(1) + IDX_W'(cfgTwoStop);

  always_comb begin
    strobe            = '0;
    strobe.kind       = KIND_START;
    strobe.frameStart = (state == ST_IDLE) && lineFall;
    if (state != ST_IDLE && tick) begin
      strobe.sampleA = (tickCnt == SAMP_A);
      strobe.sampleB = (tickCnt == SAMP_B);
      strobe.resolve = (tickCnt == SAMP_C);
    end
    if (state == ST_BITS) begin
      if (bitIdx < dataBits)                     strobe.kind = KIND_DATA;
      else if (bitIdx == dataBits && cfgParityEn) strobe.kind = KIND_PARITY;
      else                                        strobe.kind = KIND_STOP;
      strobe.lastBit = (bitIdx == totalBits - IDX_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      if (state != ST_IDLE && tick)
        tickCnt <= (tickCnt == TICK_LAST) ? '0 : tickCnt + TW'(1);
      case (state)
        ST_IDLE: if (lineFall) begin
          state   <= ST_START;
          tickCnt <= '0;
        end
        ST_START: if (strobe.resolve) begin
          state  <= vote ? ST_IDLE : ST_BITS;
          bitIdx <= '0;
        end
        ST_BITS: if (strobe.resolve) begin
          if (strobe.lastBit) state <= ST_IDLE;
          else                bitIdx <= bitIdx + IDX_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameStart |=> !strobe.frameStart);

  // R1
  vote_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.resolve |-> !strobe.sampleA && !strobe.sampleB && tick);

endmodule

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BREAK_LEN = 10,
  parameter int SYNC_LEN  = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            rxd,
  input  logic            cfgNineBit,
  input  logic            cfgParityOdd,
  input  logic            rdStrobe,
  input  rxStrobe_t       strobe,
  output logic            lineFall,
  output logic            vote,
  output logic [DATA_W:0] rxWord,
  output logic            rxFull,
  output logic            rxNoise,
  output logic            rxFrameErr,
  output logic            rxOverrun,
  output logic            rxBreak
);

  localparam int RUN_W = $clog2(BREAK_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(BREAK_LEN);

  logic [SYNC_LEN-1:0] syncQ;
  logic                lineQ;
  logic                line;
  logic                sampA, sampB;
  logic                noisy;
  logic [DATA_W:0]     shiftQ;
  logic                parityAcc, noiseAcc, frameErrAcc;
  logic [RUN_W-1:0]    zeroRun;
  logic                doneQ, breakQ;

  assign line     = syncQ[SYNC_LEN-1];
  assign lineFall = lineQ && !line;
  assign vote     = (sampA & sampB) | (sampA & line) | (sampB & line);
  assign noisy    = (sampA != sampB) || (sampB != line);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
      lineQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_LEN-2:0], rxd};
      lineQ <= line;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampA       <= 1'b1;
      sampB       <= 1'b1;
      shiftQ      <= '0;
      parityAcc   <= 1'b0;
      noiseAcc    <= 1'b0;
      frameErrAcc <= 1'b0;
      zeroRun     <= '0;
      doneQ       <= 1'b0;
      breakQ      <= 1'b0;
    end else begin
      doneQ  <= 1'b0;
      breakQ <= 1'b0;
      if (strobe.sampleA) sampA <= line;
      if (strobe.sampleB) sampB <= line;
      if (strobe.frameStart) begin
        shiftQ      <= '0;
        parityAcc   <= 1'b0;
        noiseAcc    <= 1'b0;
        frameErrAcc <= 1'b0;
        zeroRun     <= '0;
      end else if (strobe.resolve) begin
        noiseAcc <= noiseAcc | noisy;
        if (vote) zeroRun <= '0;
        else if (zeroRun != RUN_MAX) zeroRun <= zeroRun + RUN_W'(1);
        breakQ <= !vote && (zeroRun == RUN_MAX - RUN_W'(1));
        case (strobe.kind)
          KIND_DATA: begin
            shiftQ    <= {vote, shiftQ[DATA_W:1]};
            parityAcc <= parityAcc ^ vote;
          end
          KIND_PARITY: frameErrAcc <= frameErrAcc | (parityAcc ^ vote ^ cfgParityOdd);
          KIND_STOP:   frameErrAcc <= frameErrAcc | !vote;
          default: ;
        endcase
        doneQ <= strobe.lastBit;
      end
    end
  end

  // holding stage, falling edge of the master clock
  logic [DATA_W:0] wordQ;
  logic            fullQ, noiseQ, frameErrQ, overrunQ, breakFlagQ;

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ      <= '0;
      fullQ      <= 1'b0;
      noiseQ     <= 1'b0;
      frameErrQ  <= 1'b0;
      overrunQ   <= 1'b0;
      breakFlagQ <= 1'b0;
    end else begin
      if (rdStrobe) begin
        fullQ      <= 1'b0;
        overrunQ   <= 1'b0;
        breakFlagQ <= 1'b0;
      end
      if (doneQ) begin
        if (fullQ && !rdStrobe) overrunQ <= 1'b1;
        else begin
          wordQ     <= cfgNineBit ? shiftQ : {1'b0, shiftQ[DATA_W:1]};
          noiseQ    <= noiseAcc;
          frameErrQ <= frameErrAcc;
          fullQ     <= 1'b1;
        end
      end
      if (breakQ) breakFlagQ <= 1'b1;
    end
  end

  assign rxWord     = wordQ;
  assign rxFull     = fullQ;
  assign rxNoise    = noiseQ;
  assign rxFrameErr = frameErrQ;
  assign rxOverrun  = overrunQ;
  assign rxBreak    = breakFlagQ;

  // R6
  full_load_chk: assert property (@(negedge clk) disable iff (!rstN)
    (doneQ && !fullQ) |=> fullQ);

  // R8
  overrun_keep_chk: assert property (@(negedge clk) disable iff (!rstN)
    (doneQ && fullQ && !rdStrobe) |=> (overrunQ && $stable(wordQ)));

  // R7
  read_clear_chk: assert property (@(negedge clk) disable iff (!rstN)
    (rdStrobe && !doneQ) |=> (!fullQ && !overrunQ));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

endmodule

// File: rtl/uart_rx_majority.sv
module uart_rx_majority
  import uart_rx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_W    = 8,
  parameter int BREAK_LEN = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  input  logic            rxd,
  input  logic            cfgNineBit,
  input  logic            cfgParityEn,
  input  logic            cfgParityOdd,
  input  logic            cfgTwoStop,
  input  logic            enFullIrq,
  input  logic            enOverrunIrq,
  input  logic            enBreakIrq,
  input  logic            rdStrobe,
  output logic [DATA_W:0] rxWord,
  output logic            rxFull,
  output logic            rxNoise,
  output logic            rxFrameErr,
  output logic            rxOverrun,
  output logic            rxBreak,
  output logic            irqFull,
  output logic            irqOverrun,
  output logic            irqBreak
);

  rxStrobe_t strobe;
  logic      lineFall;
  logic      vote;

  uart_rx_ctrl #(.OVS(OVS), .DATA_W(DATA_W)) ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .lineFall(lineFall), .vote(vote),
    .cfgNineBit(cfgNineBit), .cfgParityEn(cfgParityEn), .cfgTwoStop(cfgTwoStop),
    .strobe(strobe)
  );

  uart_rx_datapath #(.DATA_W(DATA_W), .BREAK_LEN(BREAK_LEN), .SYNC_LEN(2)) dpath (
    .clk(clk), .rstN(rstN), .rxd(rxd), .cfgNineBit(cfgNineBit),
    .cfgParityOdd(cfgParityOdd), .rdStrobe(rdStrobe), .strobe(strobe),
    .lineFall(lineFall), .vote(vote), .rxWord(rxWord), .rxFull(rxFull),
    .rxNoise(rxNoise), .rxFrameErr(rxFrameErr), .rxOverrun(rxOverrun),
    .rxBreak(rxBreak)
  );

  assign irqFull    = rxFull & enFullIrq;
  assign irqOverrun = rxOverrun & enOverrunIrq;
  assign irqBreak   = rxBreak & enBreakIrq;

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqFull || irqOverrun || irqBreak) |-> (rxFull || rxOverrun || rxBreak));

endmodule

// File: tb/uart_rx_majority_test.sv
module uart_rx_majority_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic rxd = 1'b1;
  logic cfgNineBit = 0, cfgParityEn = 0, cfgParityOdd = 0, cfgTwoStop = 0;
  logic enFullIrq = 0, enOverrunIrq = 0, enBreakIrq = 0;
  logic rdStrobe = 0;
  logic [8:0] rxWord;
  logic rxFull, rxNoise, rxFrameErr, rxOverrun, rxBreak;
  logic irqFull, irqOverrun, irqBreak;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    tick <= (cyc % 4 == 3);
  end

  uart_rx_majority uut (
    .clk(clk), .rstN(rstN), .tick(tick), .rxd(rxd),
    .cfgNineBit(cfgNineBit), .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd),
    .cfgTwoStop(cfgTwoStop), .enFullIrq(enFullIrq), .enOverrunIrq(enOverrunIrq),
    .enBreakIrq(enBreakIrq), .rdStrobe(rdStrobe), .rxWord(rxWord), .rxFull(rxFull),
    .rxNoise(rxNoise), .rxFrameErr(rxFrameErr), .rxOverrun(rxOverrun),
    .rxBreak(rxBreak), .irqFull(irqFull), .irqOverrun(irqOverrun), .irqBreak(irqBreak)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!tick);
    end
    #2;
  endtask

  // frame bits, LSB = start bit
  logic [15:0] fb;
  int          fbLen;

  function automatic int maxZeroRun(input logic [15:0] bits, input int len);
    int run = 0, best = 0;
    for (int i = 0; i < len; i++) begin
      run  = bits[i] ? 0 : run + 1;
      best = (run > best) ? run : best;
    end
    return best;
  endfunction

  function automatic logic [8:0] expWord(input logic [8:0] d, input logic nine);
    return nine ? d : {1'b0, d[7:0]};
  endfunction

  function automatic logic expFrameErr(input logic parEn, input logic parBad,
                                       input logic s1, input logic two, input logic s2);
    return (parEn && parBad) || !s1 || (two && !s2);
  endfunction

  task automatic buildFrame(input logic [8:0] d, input logic parBad,
                            input logic s1, input logic s2);
    int nd = cfgNineBit ? 9 : 8;
    logic p = cfgParityOdd ^ parBad;
    fb = '1;
    fbLen = 0;
    fb[fbLen] = 1'b0; fbLen++;
    for (int i = 0; i < nd; i++) begin
      fb[fbLen] = d[i]; fbLen++;
      p = p ^ d[i];
    end
    if (cfgParityEn) begin fb[fbLen] = p; fbLen++; end
    fb[fbLen] = s1; fbLen++;
    if (cfgTwoStop) begin fb[fbLen] = s2; fbLen++; end
  endtask

  // glitch inverts the line over the window seen by the middle vote sample
  task automatic sendFrame(input int glitchAt);
    waitTicks(1);
    for (int b = 0; b < fbLen; b++) begin
      rxd = fb[b];
      if (b == glitchAt) begin
        waitTicks(8);
        rxd = ~fb[b];
        waitTicks(1);
        rxd = fb[b];
        waitTicks(7);
      end else begin
        waitTicks(16);
      end
    end
    rxd = 1'b1;
  endtask

  task automatic doRead();
    @(posedge clk); #2 rdStrobe = 1'b1;
    @(posedge clk); #2 rdStrobe = 1'b0;
    #10;
  endtask

  task automatic runFrame(input string tag, input logic [8:0] d, input logic parBad,
                          input logic s1, input logic s2, input int glitchAt);
    logic brk;
    buildFrame(d, parBad, s1, s2);
    brk = (maxZeroRun(fb, fbLen) >= 10);
    sendFrame(glitchAt);
    waitTicks(20);
    #10;
    chk({tag, " R6 full"}, rxFull, 1);
    chk({tag, " R1 R3 word"}, rxWord, expWord(d, cfgNineBit));
    chk({tag, " R2 noise"}, rxNoise, (glitchAt >= 0 && glitchAt < fbLen));
    chk({tag, " R4 frameErr"}, rxFrameErr,
        expFrameErr(cfgParityEn, parBad, s1, cfgTwoStop, s2));
    chk({tag, " R5 break"}, rxBreak, brk);
    chk({tag, " R9 irqFull"}, irqFull, enFullIrq);
    chk({tag, " R9 irqBreak"}, irqBreak, brk & enBreakIrq);
    doRead();
    chk({tag, " R7 full cleared"}, rxFull, 0);
    chk({tag, " R7 break cleared"}, rxBreak, 0);
    chk({tag, " R7 overrun clear"}, rxOverrun, 0);
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;
    #10;
    // R11 reset state
    chk("R11 full", rxFull, 0);
    chk("R11 flags", {rxNoise, rxFrameErr, rxOverrun, rxBreak}, 0);
    chk("R11 irqs", {irqFull, irqOverrun, irqBreak}, 0);

    // directed: plain 8-bit frame, noise on start and stop bits
    enFullIrq = 1; enOverrunIrq = 1; enBreakIrq = 1;
    runFrame("d8", 9'h0A5, 0, 1, 1, -1);
    runFrame("d8noiseStart", 9'h03C, 0, 1, 1, 0);
    runFrame("d8noiseStop", 9'h0C3, 0, 1, 1, 9);

    // directed: 9-bit, even/odd parity, bad parity, two stops with bad second stop
    cfgNineBit = 1;
    runFrame("d9", 9'h1F0, 0, 1, 1, 4);
    cfgNineBit = 0; cfgParityEn = 1; cfgParityOdd = 0;
    runFrame("parEven", 9'h013, 0, 1, 1, -1);
    runFrame("parEvenBad", 9'h013, 1, 1, 1, -1);
    cfgParityOdd = 1;
    runFrame("parOdd", 9'h0F1, 0, 1, 1, 9);
    cfgParityEn = 0; cfgTwoStop = 1;
    runFrame("twoStopBad", 9'h055, 0, 1, 0, -1);
    cfgTwoStop = 0;

    // R5 break: line held low from start through stop
    enBreakIrq = 1;
    runFrame("R5 break8", 9'h000, 0, 0, 0, -1);
    enBreakIrq = 0;
    runFrame("R5 breakMasked", 9'h000, 0, 0, 0, 3);

    // R10 false start: short low pulse
    waitTicks(1);
    rxd = 1'b0;
    waitTicks(4);
    rxd = 1'b1;
    waitTicks(40);
    #10;
    chk("R10 false start no word", rxFull, 0);
    runFrame("R10 after false start", 9'h08E, 0, 1, 1, -1);

    // R8 overrun: two frames without a read, overrun irq disabled then enabled
    enOverrunIrq = 0;
    buildFrame(9'h011, 0, 1, 1);
    sendFrame(-1);
    waitTicks(4);
    buildFrame(9'h0EE, 1, 1, 1);
    sendFrame(2);
    waitTicks(20);
    #10;
    chk("R8 overrun flag", rxOverrun, 1);
    chk("R8 old word kept", rxWord, 9'h011);
    chk("R8 old noise kept", rxNoise, 0);
    chk("R9 overrun irq masked", irqOverrun, 0);
    enOverrunIrq = 1;
    #1;
    chk("R9 overrun irq enabled", irqOverrun, 1);
    doRead();
    chk("R7 overrun cleared", rxOverrun, 0);
    chk("R7 full cleared after overrun", rxFull, 0);

    // random frames
    for (int n = 0; n < 32; n++) begin
      logic [8:0] d;
      int g;
      cfgNineBit   = $urandom % 2;
      cfgParityEn  = $urandom % 2;
      cfgParityOdd = $urandom % 2;
      cfgTwoStop   = $urandom % 2;
      enFullIrq    = $urandom % 2;
      enBreakIrq   = $urandom % 2;
      d = 9'($urandom);
      if ($urandom % 6 == 0) d = 9'h000;
      g = ($urandom % 2) ? -1 : int'($urandom % 13);
      runFrame($sformatf("rnd%0d", n), d, ($urandom % 4) == 0,
               ($urandom % 7) != 0, ($urandom % 7) != 0, g);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule